// File: doc/BRIEF.md
# Cipher Key and IV Register Bank

This block holds the key and chaining-vector context for a 64-bit block cipher engine that runs either single DES or triple DES. A host writes three 64-bit key registers and one 64-bit IV register over a 32-bit bus, one half at a time. The assembled values are presented continuously to the cipher datapath. After each processed block, the datapath writes the updated chaining value back into the IV register.

The key registers cannot be read back. Any attempt to read one returns zero and raises an address-error pulse. A write to the first key also lands in the third key, so two-key triple DES needs only two key writes. The bank enforces the order in which keys are loaded. Writes that break the mode or ordering rules are dropped and flagged.

Reading the IV while the engine is busy is refused and flagged. If a host IV write and a datapath IV update arrive in the same cycle, the datapath wins and the clash is flagged. Every error output is a registered one-cycle pulse meant for an interrupt controller.

Top module: `keyiv_bank`

## Requirements
- R1: Asynchronous active-low reset clears key_a, key_b, key_c, chain_iv and keys_loaded to zero.
- R2: A read with reg_idx[2:1] of 0, 1 or 2 (a key register) returns rdata of zero, and err_addr pulses high for exactly the cycle after the read edge.
- R3: A write to the first key (reg_idx[2:1]=0) stores wdata in both key_a and key_c in the selected lane. keys_loaded is set from the next cycle and stays set until reset.
- R4: While single_des is high, writes to key two (reg_idx[2:1]=1) or key three (reg_idx[2:1]=2) leave key_b and key_c unchanged and pulse err_key.
- R5: In three-key mode (single_des=0, two_key=0), a key two write is accepted only after a key one write since reset, and a key three write only after a key two write that followed the latest key one write. A rejected write changes nothing and pulses err_key. An accepted key three write overrides the copy made by the key one write.
- R6: In two-key mode (two_key=1, single_des=0), writes to key three are rejected with err_key, so key_c keeps the copy of key_a.
- R7: reg_idx[0] selects the lane: 0 is bits 31:0 and 1 is bits 63:32. A write changes only that lane, and an IV read returns that lane of chain_iv.
- R8: An IV read (reg_idx[2:1]=3) while busy is high returns zero and pulses err_ctx.
- R9: When iv_upd_valid is high, chain_iv takes iv_upd_data on the next edge.
- R10: A host IV write in the same cycle as iv_upd_valid is dropped, the datapath value is stored, and err_ctx pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| reg_idx | input | 3 | Register select [2:1] and lane select [0] |
| wdata | input | BUS_W | Host write data |
| rdata | output | BUS_W | Host read data (combinational) |
| single_des | input | 1 | Engine set to single DES |
| two_key | input | 1 | Key size is 16 bytes (two-key triple DES) |
| busy | input | 1 | Engine is processing data |
| iv_upd_valid | input | 1 | Datapath IV update strobe |
| iv_upd_data | input | 2*BUS_W | Updated chaining value |
| key_a | output | 2*BUS_W | First key |
| key_b | output | 2*BUS_W | Second key |
| key_c | output | 2*BUS_W | Third key |
| chain_iv | output | 2*BUS_W | Current IV |
| keys_loaded | output | 1 | First key has been written since reset |
| err_addr | output | 1 | Key read error pulse |
| err_key | output | 1 | Key mode or ordering violation pulse |
| err_ctx | output | 1 | Busy IV read or IV write clash pulse |

## Verification
The bench builds the bank with its default BUS_W of 32, which gives the 64-bit cipher block split into two lanes. With that split, lane isolation can be checked: the bench writes distinct patterns into each half and confirms that the other half keeps its value. The default width also lets the bench follow the key ordering rules through a rejected early third-key write and a later override of the first-key copy, all within one reset period.

// File: rtl/keyiv_bank.sv
module keyiv_bank #(
  parameter int BUS_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [2:0]         reg_idx,
  input  logic [BUS_W-1:0]   wdata,
  output logic [BUS_W-1:0]   rdata,
  input  logic               single_des,
  input  logic               two_key,
  input  logic               busy,
  input  logic               iv_upd_valid,
  input  logic [2*BUS_W-1:0] iv_upd_data,
  output logic [2*BUS_W-1:0] key_a,
  output logic [2*BUS_W-1:0] key_b,
  output logic [2*BUS_W-1:0] key_c,
  output logic [2*BUS_W-1:0] chain_iv,
  output logic               keys_loaded,
  output logic               err_addr,
  output logic               err_key,
  output logic               err_ctx
);
  localparam int BLK_W = 2 * BUS_W;
  localparam logic [1:0] SEL_KA = 2'd0, SEL_KB = 2'd1, SEL_KC = 2'd2, SEL_IV = 2'd3;

  logic [1:0] sel;
  logic       hi;
  logic [1:0] stage;
  logic       wr_ka, wr_kb, wr_kc, wr_iv;
  logic       kb_ok, kc_ok, rule_bad;

  assign sel = reg_idx[2:1];
  assign hi  = reg_idx[0];

  assign wr_ka = wr_en && sel == SEL_KA;
  assign wr_kb = wr_en && sel == SEL_KB;
  assign wr_kc = wr_en && sel == SEL_KC;
  assign wr_iv = wr_en && sel == SEL_IV;

  assign kb_ok    = wr_kb && !single_des && stage != 2'd0;
  assign kc_ok    = wr_kc && !single_des && !two_key && stage == 2'd2;
  assign rule_bad = (wr_kb && !kb_ok) || (wr_kc && !kc_ok);

  assign rdata = (rd_en && sel == SEL_IV && !busy)
               ? (hi ? chain_iv[BLK_W-1:BUS_W] : chain_iv[BUS_W-1:0])
               : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_a       <= '0;
      key_b       <= '0;
      key_c       <= '0;
      chain_iv    <= '0;
      stage       <= 2'd0;
      keys_loaded <= 1'b0;
      err_addr    <= 1'b0;
      err_key     <= 1'b0;
      err_ctx     <= 1'b0;
    end else begin
      if (wr_ka) begin
        if (hi) begin
          key_a[BLK_W-1:BUS_W] <= wdata;
          key_c[BLK_W-1:BUS_W] <= wdata;
        end else begin
          key_a[BUS_W-1:0] <= wdata;
          key_c[BUS_W-1:0] <= wdata;
        end
        stage       <= 2'd1;
        keys_loaded <= 1'b1;
      end
      if (kb_ok) begin
        if (hi) key_b[BLK_W-1:BUS_W] <= wdata;
        else    key_b[BUS_W-1:0]     <= wdata;
        stage <= 2'd2;
      end
      if (kc_ok) begin
        if (hi) key_c[BLK_W-1:BUS_W] <= wdata;
        else    key_c[BUS_W-1:0]     <= wdata;
      end
      if (iv_upd_valid)
        chain_iv <= iv_upd_data;
      else if (wr_iv) begin
        if (hi) chain_iv[BLK_W-1:BUS_W] <= wdata;
        else    chain_iv[BUS_W-1:0]     <= wdata;
      end
      err_addr <= rd_en && sel != SEL_IV;
      err_key  <= rule_bad;
      err_ctx  <= (rd_en && sel == SEL_IV && busy) || (wr_iv && iv_upd_valid);
    end
  end

  p_keyrd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && reg_idx[2:1] != 2'd3 |-> rdata == '0);
  p_keyrd_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && reg_idx[2:1] != 2'd3 |=> err_addr);
  p_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && reg_idx[2:1] == 2'd0 |=>
      ($past(reg_idx[0]) ? key_a[BLK_W-1:BUS_W] == key_c[BLK_W-1:BUS_W]
                         : key_a[BUS_W-1:0] == key_c[BUS_W-1:0]));
  p_loaded_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(keys_loaded));
  p_single_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    single_des && wr_en && (reg_idx[2:1] == 2'd1 || reg_idx[2:1] == 2'd2)
      |=> $stable(key_b) && $stable(key_c) && err_key);
  p_busy_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && reg_idx[2:1] == 2'd3 && busy |=> err_ctx);
  p_upd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iv_upd_valid |=> chain_iv == $past(iv_upd_data));
  p_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
    iv_upd_valid && wr_en && reg_idx[2:1] == 2'd3 |=> err_ctx);
endmodule

// File: tb/keyiv_bank_test.sv
module keyiv_bank_test;
  localparam int BW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, single_des = 0, two_key = 0, busy = 0, iv_upd_valid = 0;
  logic [2:0] reg_idx = '0;
  logic [BW-1:0] wdata = '0;
  logic [BW-1:0] rdata;
  logic [2*BW-1:0] iv_upd_data = '0;
  logic [2*BW-1:0] key_a, key_b, key_c, chain_iv;
  logic keys_loaded, err_addr, err_key, err_ctx;
  int n_chk = 0, n_fail = 0;
  logic e_addr, e_key, e_ctx;
  logic [BW-1:0] rd_val;

  always #2.5 clk = ~clk;

  keyiv_bank #(.BUS_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
    .wdata(wdata), .rdata(rdata), .single_des(single_des), .two_key(two_key),
    .busy(busy), .iv_upd_valid(iv_upd_valid), .iv_upd_data(iv_upd_data),
    .key_a(key_a), .key_b(key_b), .key_c(key_c), .chain_iv(chain_iv),
    .keys_loaded(keys_loaded), .err_addr(err_addr), .err_key(err_key), .err_ctx(err_ctx));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [BW-1:0] d);
    @(negedge clk);
    wr_en = 1; reg_idx = idx; wdata = d;
    @(posedge clk); #1;
    e_addr = err_addr; e_key = err_key; e_ctx = err_ctx;
    wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] idx);
    @(negedge clk);
    rd_en = 1; reg_idx = idx;
    #1 rd_val = rdata;
    @(posedge clk); #1;
    e_addr = err_addr; e_key = err_key; e_ctx = err_ctx;
    rd_en = 0;
  endtask

  task automatic t_reset;
    check(key_a == 0 && key_b == 0 && key_c == 0, "R1 keys", {key_a[31:0], key_c[31:0]}, 0);
    check(chain_iv == 0 && !keys_loaded, "R1 iv/loaded", chain_iv, 0);
  endtask

  task automatic t_early_kb;
    wr(3'b010, 32'h1111_2222);
    check(key_b == 0 && e_key, "R5 K2 before K1", key_b, 0);
  endtask

  task automatic t_ka_copy;
    wr(3'b000, 32'hA0A0_0001);
    wr(3'b001, 32'hA1A1_0002);
    check(key_a == 64'hA1A1_0002_A0A0_0001, "R3 key_a", key_a, 64'hA1A1_0002_A0A0_0001);
    check(key_c == 64'hA1A1_0002_A0A0_0001, "R3 key_c copy", key_c, 64'hA1A1_0002_A0A0_0001);
    check(keys_loaded, "R3 keys_loaded", {63'b0, keys_loaded}, 1);
  endtask

  task automatic t_key_read;
    rd(3'b000);
    check(rd_val == 0, "R2 key read data", rd_val, 0);
    check(e_addr, "R2 err_addr", {63'b0, e_addr}, 1);
    @(posedge clk); #1;
    check(!err_addr, "R2 single pulse", {63'b0, err_addr}, 0);
  endtask

  task automatic t_order;
    wr(3'b100, 32'hDEAD_0000);
    check(key_c == 64'hA1A1_0002_A0A0_0001 && e_key, "R5 K3 before K2", key_c, 64'hA1A1_0002_A0A0_0001);
    wr(3'b010, 32'hB0B0_0003);
    wr(3'b011, 32'hB1B1_0004);
    check(key_b == 64'hB1B1_0004_B0B0_0003 && !e_key, "R5 K2 accepted", key_b, 64'hB1B1_0004_B0B0_0003);
    wr(3'b100, 32'hC0C0_0005);
    wr(3'b101, 32'hC1C1_0006);
    check(key_c == 64'hC1C1_0006_C0C0_0005 && !e_key, "R5 K3 override", key_c, 64'hC1C1_0006_C0C0_0005);
    check(keys_loaded, "R3 loaded stays", {63'b0, keys_loaded}, 1);
  endtask

  task automatic t_single;
    single_des = 1;
    wr(3'b010, 32'h5555_5555);
    check(key_b == 64'hB1B1_0004_B0B0_0003 && e_key, "R4 K2 locked", key_b, 64'hB1B1_0004_B0B0_0003);
    wr(3'b101, 32'h6666_6666);
    check(key_c == 64'hC1C1_0006_C0C0_0005 && e_key, "R4 K3 locked", key_c, 64'hC1C1_0006_C0C0_0005);
    single_des = 0;
  endtask

  task automatic t_two_key;
    two_key = 1;
    wr(3'b000, 32'h7070_0007);
    wr(3'b001, 32'h7171_0008);
    wr(3'b010, 32'h8080_0009);
    check(key_b[31:0] == 32'h8080_0009 && !e_key, "R6 K2 ok", key_b, 64'h8080_0009);
    wr(3'b100, 32'h9999_9999);
    check(key_c == 64'h7171_0008_7070_0007 && e_key, "R6 K3 rejected", key_c, 64'h7171_0008_7070_0007);
    two_key = 0;
  endtask

  task automatic t_iv_lanes;
    wr(3'b110, 32'h1234_5678);
    wr(3'b111, 32'h9ABC_DEF0);
    check(chain_iv == 64'h9ABC_DEF0_1234_5678, "R7 iv write", chain_iv, 64'h9ABC_DEF0_1234_5678);
    wr(3'b111, 32'hFFFF_0000);
    check(chain_iv == 64'hFFFF_0000_1234_5678, "R7 upper lane only", chain_iv, 64'hFFFF_0000_1234_5678);
    rd(3'b110);
    check(rd_val == 32'h1234_5678 && !e_ctx, "R7 read low", rd_val, 32'h1234_5678);
    rd(3'b111);
    check(rd_val == 32'hFFFF_0000, "R7 read high", rd_val, 32'hFFFF_0000);
  endtask

  task automatic t_busy_read;
    busy = 1;
    rd(3'b110);
    check(rd_val == 0 && e_ctx, "R8 busy read", {rd_val, 31'b0, e_ctx}, 1);
    busy = 0;
  endtask

  task automatic t_update;
    @(negedge clk);
    iv_upd_valid = 1; iv_upd_data = 64'h0BAD_F00D_CAFE_BEEF;
    @(posedge clk); #1;
    iv_upd_valid = 0;
    check(chain_iv == 64'h0BAD_F00D_CAFE_BEEF && !err_ctx, "R9 update", chain_iv, 64'h0BAD_F00D_CAFE_BEEF);
  endtask

  task automatic t_clash;
    @(negedge clk);
    iv_upd_valid = 1; iv_upd_data = 64'h1357_9BDF_2468_ACE0;
    wr_en = 1; reg_idx = 3'b110; wdata = 32'h7777_7777;
    @(posedge clk); #1;
    iv_upd_valid = 0; wr_en = 0;
    check(chain_iv == 64'h1357_9BDF_2468_ACE0, "R10 datapath wins", chain_iv, 64'h1357_9BDF_2468_ACE0);
    check(err_ctx, "R10 err_ctx", {63'b0, err_ctx}, 1);
  endtask

  initial begin
    #12 t_reset();
    @(negedge clk) rst_n = 1;
    t_early_kb();
    t_ka_copy();
    t_key_read();
    t_order();
    t_single();
    t_two_key();
    t_iv_lanes();
    t_busy_read();
    t_update();
    t_clash();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule